// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block holds the digital control for a successive-approximation ADC. A 3-bit source field chooses which event starts a conversion. The choices are a software busy write, either of two timer overflow pulses, a rising edge on an external convert pin, or a software start aimed at a companion converter. Once started, the block raises a busy flag. It steps a trial DAC code from the most significant bit down to the least, one bit per SAR clock, and keeps each bit that the comparator accepts. When the last bit is decided it writes the result register, drops busy and sets an interrupt flag.

The SAR clock is an enable pulse derived from the system clock through a programmable divide field, so no second clock domain exists. A low-power tracking bit changes how the track/hold control output behaves. When the bit is clear, the input tracks at all times except during a conversion. When the bit is set, each conversion begins with a tracking phase of three SAR clocks. In external-pin mode the pin level itself opens the tracking window and its rising edge starts the conversion. Software may clear the flag, write busy, and poll the flag to learn that the conversion has completed.

Top module: `sar_seq`

## Requirements
- R1: `start_mode` encodes the start source: 0 = `busy_wr`, 1 = `tmr3_ovf`, 2 = rising edge of `cnv_pin`, 3 = `tmr2_ovf`, 4 = `peer_start`; codes 5, 6 and 7 start nothing. A selected pulse that is high at a clock edge while idle makes `busy` read 1 after that edge.
- R2: Start sources other than the one selected by `start_mode` have no effect on `busy`.
- R3: With `trk_lp` = 0, `busy` stays high for exactly 8*(`div_sel`+1) system clocks, because one SAR clock lasts `div_sel`+1 system clocks.
- R4: With `trk_lp` = 1 and a source other than the pin, `busy` stays high for 11*(`div_sel`+1) clocks, and `track` is high for the first 3*(`div_sel`+1) of them.
- R5: With `trk_lp` = 1 and the pin source, `track` follows the inverted synchronized pin while idle. No tracking phase is inserted, so `busy` lasts 8*(`div_sel`+1) clocks and `track` is low throughout it.
- R6: With `trk_lp` = 0, `track` is 1 while idle and 0 while busy.
- R7: For a comparator that outputs 1 when the input value is at or above `dac_code`, the finished `result` equals the input value (8 bits, MSB decided first). `dac_code` is 0 while idle.
- R8: `int_flag` becomes 1 on the edge where `busy` falls. It is cleared by a one-cycle `int_clr` and stays set otherwise. `irq` equals `int_flag` AND `int_en`.
- R9: Start events that arrive while `busy` is 1 are ignored and do not lengthen the conversion.
- R10: `result` holds its previous value during a conversion and changes only when the conversion completes.
- R11: `cnv_pin` passes through a two-flop synchronizer. After the pin rises before an edge E0, `busy` is still 0 after edges E0 and E1 and reads 1 after E2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| busy_wr | input | 1 | One-cycle software write of 1 to busy |
| start_mode | input | 3 | Start source select |
| trk_lp | input | 1 | Low-power tracking mode enable |
| div_sel | input | 4 | SAR clock divide field (period = value+1) |
| int_clr | input | 1 | One-cycle interrupt flag clear |
| int_en | input | 1 | Interrupt request enable |
| tmr3_ovf | input | 1 | Timer 3 overflow pulse |
| tmr2_ovf | input | 1 | Timer 2 overflow pulse |
| cnv_pin | input | 1 | Asynchronous external convert-start pin |
| peer_start | input | 1 | Companion converter software start pulse |
| cmp_in | input | 1 | Comparator: 1 when input is at or above `dac_code` |
| dac_code | output | 8 | Trial code for the DAC |
| track | output | 1 | Track (1) / hold (0) control |
| busy | output | 1 | Conversion in progress |
| int_flag | output | 1 | Conversion-complete flag |
| irq | output | 1 | Interrupt request |
| result | output | 8 | Last completed conversion result |

## Verification
Directed conversions cover the input values 0, 255, 127 and 128. These tell apart errors at either rail and at the MSB decision boundary. A constrained random mix then draws the source, tracking mode, divide value, interrupt enable and input value. Measuring busy and track durations in each case separates divider off-by-one faults from a missing or misplaced tracking phase. Pulses on unselected sources, pulses during a conversion, and the reserved mode codes show that triggers are filtered correctly. Counting the pin latency cycle by cycle exposes a missing or extra synchronizer stage.

// File: rtl/sar_pkg.sv
// Package: shared encodings for the SAR conversion sequencer.
// Assumes: the start source field is 3 bits wide; codes above 4 are reserved.
package sar_pkg;
    typedef enum logic [2:0] {
        SRC_SW    = 3'd0,
        SRC_TMR_A = 3'd1,
        SRC_PIN   = 3'd2,
        SRC_TMR_B = 3'd3,
        SRC_PEER  = 3'd4
    } start_src_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_TRACK = 2'd1,
        ST_CONV  = 2'd2
    } seq_state_e;

    localparam int TRACK_TICKS = 3;
endpackage

// File: rtl/sar_clkdiv.sv
// Module: SAR clock enable generator.
// Produces a one-cycle tick every div_sel+1 system clocks while run is high.
// Assumes: the counter is held at zero while idle, so the first tick of a
// conversion comes div_sel+1 cycles after run rises.
module sar_clkdiv #(
    parameter int DIVW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [DIVW-1:0] div_sel,
    output logic            tick
);
    logic [DIVW-1:0] cnt;

    assign tick = run && (cnt == div_sel);

    // Count system clocks between SAR ticks; restart on each tick or when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/sar_trigger.sv
// Module: start-source synchronizer and selector.
// The external pin is synchronized by two flops, and a third flop detects its
// rising edge. The other sources are synchronous one-cycle pulses.
// Assumes: start_mode codes 5..7 select no source.
module sar_trigger
    import sar_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] start_mode,
    input  logic       busy_wr,
    input  logic       tmr_a,
    input  logic       pin_async,
    input  logic       tmr_b,
    input  logic       peer,
    output logic       start,
    output logic       pin_level,
    output logic       pin_sel
);
    logic s1, s2, s3;
    logic pin_rise;

    // Two-stage synchronizer plus an edge-history flop for the convert pin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
            s3 <= 1'b0;
        end else begin
            s1 <= pin_async;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign pin_rise  = s2 && !s3;
    assign pin_level = s2;
    assign pin_sel   = (start_mode == SRC_PIN);

    // Pick the one start source that the mode field names.
    always_comb begin
        case (start_src_e'(start_mode))
            SRC_SW:    start = busy_wr;
            SRC_TMR_A: start = tmr_a;
            SRC_PIN:   start = pin_rise;
            SRC_TMR_B: start = tmr_b;
            SRC_PEER:  start = peer;
            default:   start = 1'b0;
        endcase
    end
endmodule

// File: rtl/sar_engine.sv
// Module: tracking phase and bit-serial approximation engine.
// Accepts a start only when idle. Optionally tracks for TRACK_TICKS SAR ticks,
// then decides one bit per tick from MSB to LSB.
// Assumes: cmp_in is valid for the dac_code presented during the tick cycle.
module sar_engine
    import sar_pkg::*;
#(
    parameter int RES_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             tick,
    input  logic             trk_lp,
    input  logic             pin_sel,
    input  logic             pin_level,
    input  logic             cmp_in,
    output logic             busy,
    output logic             done,
    output logic             track,
    output logic [RES_W-1:0] dac_code,
    output logic [RES_W-1:0] result
);
    localparam int IW  = $clog2(RES_W);
    localparam int TCW = $clog2(TRACK_TICKS);
    localparam logic [RES_W-1:0] MSB_ONE = {1'b1, {(RES_W-1){1'b0}}};

    seq_state_e       state;
    logic [RES_W-1:0] trial;
    logic [IW-1:0]    bitp;
    logic [TCW-1:0]   tcnt;
    logic [RES_W-1:0] mask;
    logic [RES_W-1:0] kept;

    // Decide the bit under test from the comparator.
    always_comb begin
        mask = {{(RES_W-1){1'b0}}, 1'b1} << bitp;
        kept = cmp_in ? trial : (trial & ~mask);
    end

    assign busy     = (state != ST_IDLE);
    assign done     = (state == ST_CONV) && tick && (bitp == '0);
    assign dac_code = trial;

    // Drive the track/hold control from the mode and phase.
    always_comb begin
        case (state)
            ST_IDLE:  track = !trk_lp || (pin_sel && !pin_level);
            ST_TRACK: track = 1'b1;
            default:  track = 1'b0;
        endcase
    end

    // Sequence idle, tracking and bit decisions; load result on the last bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            trial  <= '0;
            bitp   <= '0;
            tcnt   <= '0;
            result <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        tcnt <= '0;
                        if (trk_lp && !pin_sel) begin
                            state <= ST_TRACK;
                        end else begin
                            state <= ST_CONV;
                            trial <= MSB_ONE;
                            bitp  <= IW'(RES_W - 1);
                        end
                    end
                end
                ST_TRACK: begin
                    if (tick) begin
                        if (tcnt == TCW'(TRACK_TICKS - 1)) begin
                            state <= ST_CONV;
                            trial <= MSB_ONE;
                            bitp  <= IW'(RES_W - 1);
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                end
                ST_CONV: begin
                    if (tick) begin
                        if (bitp == '0) begin
                            result <= kept;
                            trial  <= '0;
                            state  <= ST_IDLE;
                        end else begin
                            trial <= kept | (mask >> 1);
                            bitp  <= bitp - 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sar_seq.sv
// Module: top of the SAR conversion sequencer.
// Ties together start selection, SAR clock enable, the engine, and the
// completion flag with its interrupt gate.
// Assumes: busy_wr, int_clr and the timer/peer inputs are one-cycle pulses
// synchronous to clk; cnv_pin is asynchronous.
module sar_seq #(
    parameter int RES_W = 8,
    parameter int DIVW  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             busy_wr,
    input  logic [2:0]       start_mode,
    input  logic             trk_lp,
    input  logic [DIVW-1:0]  div_sel,
    input  logic             int_clr,
    input  logic             int_en,
    input  logic             tmr3_ovf,
    input  logic             tmr2_ovf,
    input  logic             cnv_pin,
    input  logic             peer_start,
    input  logic             cmp_in,
    output logic [RES_W-1:0] dac_code,
    output logic             track,
    output logic             busy,
    output logic             int_flag,
    output logic             irq,
    output logic [RES_W-1:0] result
);
    logic start, pin_level, pin_sel, tick, done;

    sar_trigger u_trig (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_mode (start_mode),
        .busy_wr    (busy_wr),
        .tmr_a      (tmr3_ovf),
        .pin_async  (cnv_pin),
        .tmr_b      (tmr2_ovf),
        .peer       (peer_start),
        .start      (start),
        .pin_level  (pin_level),
        .pin_sel    (pin_sel)
    );

    sar_clkdiv #(.DIVW(DIVW)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (busy),
        .div_sel (div_sel),
        .tick    (tick)
    );

    sar_engine #(.RES_W(RES_W)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .tick      (tick),
        .trk_lp    (trk_lp),
        .pin_sel   (pin_sel),
        .pin_level (pin_level),
        .cmp_in    (cmp_in),
        .busy      (busy),
        .done      (done),
        .track     (track),
        .dac_code  (dac_code),
        .result    (result)
    );

    // Completion flag: set with the last bit decision, cleared by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_flag <= 1'b0;
        end else if (done) begin
            int_flag <= 1'b1;
        end else if (int_clr) begin
            int_flag <= 1'b0;
        end
    end

    assign irq = int_flag && int_en;
endmodule

// File: rtl/sar_seq_chk.sv
// Module: property checker for sar_seq, attached by bind.
// Assumes: trk_lp and start_mode stay stable while a conversion runs.
module sar_seq_chk #(
    parameter int RES_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy_wr,
    input logic [2:0]       start_mode,
    input logic             trk_lp,
    input logic             busy,
    input logic             track,
    input logic             int_flag,
    input logic [RES_W-1:0] dac_code,
    input logic [RES_W-1:0] result
);
    AST_FALL_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> int_flag); // R8

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(result)); // R10

    AST_HOLD_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !trk_lp) |-> !track); // R6

    AST_SW_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start_mode == 3'd0 && busy_wr) |=> busy); // R1

    AST_DAC_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (dac_code == '0)); // R7

    AST_RESERVED_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start_mode > 3'd4) |=> !busy); // R1
endmodule

bind sar_seq sar_seq_chk #(.RES_W(RES_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy_wr    (busy_wr),
    .start_mode (start_mode),
    .trk_lp     (trk_lp),
    .busy       (busy),
    .track      (track),
    .int_flag   (int_flag),
    .dac_code   (dac_code),
    .result     (result)
);

// File: tb/sar_seq_test.sv
// Bench: directed corners plus seeded random conversions for sar_seq.
module sar_seq_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       busy_wr = 1'b0;
    logic [2:0] start_mode = 3'd0;
    logic       trk_lp = 1'b0;
    logic [3:0] div_sel = 4'd0;
    logic       int_clr = 1'b0;
    logic       int_en = 1'b0;
    logic       tmr3_ovf = 1'b0;
    logic       tmr2_ovf = 1'b0;
    logic       cnv_pin = 1'b0;
    logic       peer_start = 1'b0;
    logic       cmp_in;
    logic [7:0] dac_code;
    logic       track, busy, int_flag, irq;
    logic [7:0] result;
    logic [7:0] vin = 8'd0;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;
    logic [7:0] last_res = 8'd0;

    always #2 clk = ~clk;

    // Ideal comparator model.
    assign cmp_in = (vin >= dac_code);

    sar_seq uut (
        .clk(clk), .rst_n(rst_n), .busy_wr(busy_wr), .start_mode(start_mode),
        .trk_lp(trk_lp), .div_sel(div_sel), .int_clr(int_clr), .int_en(int_en),
        .tmr3_ovf(tmr3_ovf), .tmr2_ovf(tmr2_ovf), .cnv_pin(cnv_pin),
        .peer_start(peer_start), .cmp_in(cmp_in), .dac_code(dac_code),
        .track(track), .busy(busy), .int_flag(int_flag), .irq(irq),
        .result(result)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_busy_len(input int mode, input bit lp, input int dv);
        return ((lp && mode != 2) ? 11 : 8) * (dv + 1);
    endfunction

    function automatic int exp_track_len(input int mode, input bit lp, input int dv);
        return (lp && mode != 2) ? 3 * (dv + 1) : 0;
    endfunction

    function automatic bit exp_idle_track(input int mode, input bit lp, input bit pin);
        return !lp || (mode == 2 && !pin);
    endfunction

    task automatic pulse_src(input int mode);
        case (mode)
            0: busy_wr = 1'b1;
            1: tmr3_ovf = 1'b1;
            3: tmr2_ovf = 1'b1;
            4: peer_start = 1'b1;
            default: ;
        endcase
    endtask

    task automatic clear_srcs();
        busy_wr = 1'b0; tmr3_ovf = 1'b0; tmr2_ovf = 1'b0; peer_start = 1'b0;
    endtask

    // One full conversion with timing, result and flag checks.
    task automatic run_conv(input int mode, input bit lp, input int dv,
                            input logic [7:0] v, input bit en);
        int n;
        int tr;
        start_mode = 3'(mode); trk_lp = lp; div_sel = 4'(dv); vin = v;
        int_en = en; cnv_pin = 1'b0; int_clr = 1'b1;
        @(negedge clk); int_clr = 1'b0;
        repeat (4) @(negedge clk);
        chk(track == exp_idle_track(mode, lp, 1'b0), lp ? "R5" : "R6",
            track, exp_idle_track(mode, lp, 1'b0));
        chk(int_flag == 1'b0, "R8", int_flag, 0);
        if (mode == 2) begin
            cnv_pin = 1'b1;
            @(negedge clk); chk(busy == 1'b0, "R11", busy, 0);
            @(negedge clk); chk(busy == 1'b0, "R11", busy, 0);
            @(negedge clk); chk(busy == 1'b1, "R11", busy, 1);
        end else begin
            pulse_src(mode);
            @(negedge clk); clear_srcs();
            chk(busy == 1'b1, "R1", busy, 1);
        end
        n = 0; tr = 0;
        while (busy && n < 5000) begin
            if (n == 0) chk(result == last_res, "R10", result, last_res);
            if (n == 2) begin busy_wr = 1'b1; tmr3_ovf = 1'b1; tmr2_ovf = 1'b1; peer_start = 1'b1; end
            if (n == 3) clear_srcs();
            if (track) tr++;
            n++;
            @(negedge clk);
        end
        clear_srcs();
        chk(n == exp_busy_len(mode, lp, dv), (lp && mode != 2) ? "R4/R9" : "R3/R9",
            n, exp_busy_len(mode, lp, dv));
        chk(tr == exp_track_len(mode, lp, dv), lp ? "R4/R5" : "R6",
            tr, exp_track_len(mode, lp, dv));
        chk(result == v, "R7", result, v);
        chk(int_flag == 1'b1, "R8", int_flag, 1);
        chk(irq == en, "R8", irq, en);
        last_res = v;
        cnv_pin = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // Reset state
        chk(busy == 1'b0 && int_flag == 1'b0 && irq == 1'b0, "R8", busy, 0);
        chk(result == 8'd0 && dac_code == 8'd0, "R7", result, 0);
        chk(track == 1'b1, "R6", track, 1);
        rst_n = 1'b1;
        @(negedge clk);

        // Directed rails and MSB boundary
        run_conv(0, 1'b0, 0, 8'd0, 1'b1);
        run_conv(1, 1'b0, 3, 8'd255, 1'b0);
        run_conv(3, 1'b1, 1, 8'd127, 1'b1);
        run_conv(4, 1'b0, 2, 8'd128, 1'b0);
        run_conv(2, 1'b1, 0, 8'd170, 1'b1);
        run_conv(2, 1'b0, 1, 8'd85, 1'b1);

        // Flag clear (R8)
        int_en = 1'b1; int_clr = 1'b1;
        @(negedge clk); int_clr = 1'b0;
        chk(int_flag == 1'b0 && irq == 1'b0, "R8", int_flag, 0);

        // Unselected sources ignored (R2)
        start_mode = 3'd1; trk_lp = 1'b0;
        busy_wr = 1'b1; tmr2_ovf = 1'b1; peer_start = 1'b1; cnv_pin = 1'b1;
        @(negedge clk); clear_srcs();
        repeat (4) @(negedge clk);
        chk(busy == 1'b0, "R2", busy, 0);
        cnv_pin = 1'b0;
        repeat (4) @(negedge clk);

        // Reserved codes start nothing (R1)
        for (int m = 5; m < 8; m++) begin
            start_mode = 3'(m);
            busy_wr = 1'b1; tmr3_ovf = 1'b1; tmr2_ovf = 1'b1; peer_start = 1'b1; cnv_pin = 1'b1;
            @(negedge clk); clear_srcs();
            repeat (4) @(negedge clk);
            chk(busy == 1'b0, "R1", busy, 0);
            cnv_pin = 1'b0;
            repeat (3) @(negedge clk);
        end

        // Seeded random mix
        void'($urandom(32'h5A17));
        for (int i = 0; i < 40; i++) begin
            run_conv(int'($urandom % 5), 1'($urandom), int'($urandom % 8),
                     8'($urandom), 1'($urandom));
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule